// File: doc/BRIEF.md
# Latched Multiplexed BCD Digit Readout

This block keeps a snapshot of a five-digit decimal count and shows one digit of it at a time on a 4-bit BCD bus. The count arrives as four full BCD digits plus a one-bit top digit, so it spans 0 to 19999. While the transfer control is high, the holding registers copy the live count on every clock. While it is low, they keep the last value they captured. A reader can therefore scan the digits of a stable value while the count keeps running.

A 3-bit select picks the digit. When the top select bit is high it overrides the two lower bits and picks the top digit. That digit is one bit wide, so it appears on bus bit 0 and the upper three bus bits are zero. An output enable controls the bus. The tri-state bus is modelled as a data vector plus a per-bit drive-enable vector, and the data is forced to zero while the bus is off.

Top module: `bcd_digit_readout`

## Requirements
- R1: After reset (rst_ni low), all holding registers are zero, so every select code reads 0 while transfer stays low.
- R2: On each rising clock edge where xfer_i is high, the holding registers take count_i. count_i is packed {top bit[16], digit4[15:12], digit3[11:8], digit2[7:4], digit1[3:0]}.
- R3: On a rising clock edge where xfer_i is low, the holding registers keep their value, whatever count_i does.
- R4: With sel_i[2] low, sel_i[1:0] = 0, 1, 2, 3 puts held digit 1 (least significant), 2, 3 or 4 on bcd_data_o unchanged. The output is positive-logic BCD.
- R5: With sel_i[2] high, the held top digit is selected whatever the value of sel_i[1:0].
- R6: When the top digit is selected, bcd_data_o[0] carries its value and bcd_data_o[3:1] are 0.
- R7: With oe_i high, bcd_drv_o is 4'b1111 and bcd_data_o is the selected digit. With oe_i low, bcd_drv_o is 4'b0000 (high impedance) and bcd_data_o is 0.
- R8: The select and enable paths are combinational. A change on sel_i or oe_i shows on the bus in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| count_i | input | 17 | Live count, four BCD digits plus a 1-bit top digit |
| xfer_i | input | 1 | Transfer: the registers follow count_i while high |
| sel_i | input | 3 | Digit select. Bit 2 chooses the top digit, bits 1:0 choose digit 1 to 4 |
| oe_i | input | 1 | Bus output enable |
| bcd_data_o | output | 4 | Selected digit as BCD, zero while disabled |
| bcd_drv_o | output | 4 | Per-bit drive enable; 0 means high impedance |

## Verification
A known value with a different digit in every position (1_9876) is scanned through all eight select codes. This tells apart a swapped digit order, a select bit that is ignored, and a top digit placed on the wrong bus bit. The count is then changed while transfer is low, which separates hold from follow. The enable is switched between cycles without a clock edge, which checks that the bus responds at once. Random valid BCD counts with random transfer, select and enable patterns mix load, hold and readout, and a bench model of the captured value predicts every read.

// File: rtl/bcd_readout_pkg.sv
package bcd_readout_pkg;
  localparam int unsigned DIGIT_W     = 4;
  localparam int unsigned FULL_DIGITS = 4;
  localparam int unsigned TOP_W       = 1;

  function automatic int unsigned count_width(int unsigned full, int unsigned dw, int unsigned tw);
    return full * dw + tw;
  endfunction
endpackage

// File: rtl/bcd_hold_bank.sv
module bcd_hold_bank #(
  parameter int unsigned FULL_DIGITS = bcd_readout_pkg::FULL_DIGITS,
  parameter int unsigned DIGIT_W     = bcd_readout_pkg::DIGIT_W,
  parameter int unsigned TOP_W       = bcd_readout_pkg::TOP_W,
  localparam int unsigned CNT_W      = bcd_readout_pkg::count_width(FULL_DIGITS, DIGIT_W, TOP_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             xfer_i,
  output logic [CNT_W-1:0] hold_o
);
  localparam int unsigned TOP_LSB = FULL_DIGITS * DIGIT_W;

  logic [TOP_W-1:0] top_q;

  for (genvar g = 0; g < FULL_DIGITS; g++) begin : g_digit
    logic [DIGIT_W-1:0] dig_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     dig_q <= '0;
      else if (xfer_i) dig_q <= cnt_i[g*DIGIT_W +: DIGIT_W];
    end
    assign hold_o[g*DIGIT_W +: DIGIT_W] = dig_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     top_q <= '0;
    else if (xfer_i) top_q <= cnt_i[TOP_LSB +: TOP_W];
  end
  assign hold_o[TOP_LSB +: TOP_W] = top_q;

  AST_LOAD_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_i |=> hold_o == $past(cnt_i)); // R2
  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer_i |=> $stable(hold_o)); // R3
endmodule

// File: rtl/bcd_digit_sel.sv
module bcd_digit_sel #(
  parameter int unsigned FULL_DIGITS = bcd_readout_pkg::FULL_DIGITS,
  parameter int unsigned DIGIT_W     = bcd_readout_pkg::DIGIT_W,
  parameter int unsigned TOP_W       = bcd_readout_pkg::TOP_W,
  localparam int unsigned CNT_W      = bcd_readout_pkg::count_width(FULL_DIGITS, DIGIT_W, TOP_W),
  localparam int unsigned IDX_W      = (FULL_DIGITS > 1) ? $clog2(FULL_DIGITS) : 1,
  localparam int unsigned SEL_W      = IDX_W + 1
) (
  input  logic [CNT_W-1:0]   hold_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic [DIGIT_W-1:0] digit_o
);
  localparam int unsigned TOP_LSB = FULL_DIGITS * DIGIT_W;

  logic [IDX_W-1:0] idx;
  assign idx = sel_i[IDX_W-1:0];

  // top select bit overrides the index
  always_comb begin
    digit_o = '0;
    if (sel_i[SEL_W-1]) begin
      digit_o[TOP_W-1:0] = hold_i[TOP_LSB +: TOP_W];
    end else begin
      for (int k = 0; k < FULL_DIGITS; k++) begin
        if (idx == k[IDX_W-1:0]) digit_o = hold_i[k*DIGIT_W +: DIGIT_W];
      end
    end
  end
endmodule

// File: rtl/bcd_bus_drive.sv
module bcd_bus_drive #(
  parameter int unsigned DIGIT_W = bcd_readout_pkg::DIGIT_W
) (
  input  logic               oe_i,
  input  logic [DIGIT_W-1:0] digit_i,
  output logic [DIGIT_W-1:0] data_o,
  output logic [DIGIT_W-1:0] drv_o
);
  assign drv_o  = {DIGIT_W{oe_i}};
  assign data_o = oe_i ? digit_i : '0;
endmodule

// File: rtl/bcd_digit_readout.sv
module bcd_digit_readout #(
  parameter int unsigned FULL_DIGITS = bcd_readout_pkg::FULL_DIGITS,
  parameter int unsigned DIGIT_W     = bcd_readout_pkg::DIGIT_W,
  parameter int unsigned TOP_W       = bcd_readout_pkg::TOP_W,
  localparam int unsigned CNT_W      = bcd_readout_pkg::count_width(FULL_DIGITS, DIGIT_W, TOP_W),
  localparam int unsigned IDX_W      = (FULL_DIGITS > 1) ? $clog2(FULL_DIGITS) : 1,
  localparam int unsigned SEL_W      = IDX_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [CNT_W-1:0]   count_i,
  input  logic               xfer_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic               oe_i,
  output logic [DIGIT_W-1:0] bcd_data_o,
  output logic [DIGIT_W-1:0] bcd_drv_o
);
  logic [CNT_W-1:0]   hold;
  logic [DIGIT_W-1:0] digit;

  bcd_hold_bank #(
    .FULL_DIGITS(FULL_DIGITS), .DIGIT_W(DIGIT_W), .TOP_W(TOP_W)
  ) u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .cnt_i(count_i), .xfer_i(xfer_i), .hold_o(hold)
  );

  bcd_digit_sel #(
    .FULL_DIGITS(FULL_DIGITS), .DIGIT_W(DIGIT_W), .TOP_W(TOP_W)
  ) u_sel (
    .hold_i(hold), .sel_i(sel_i), .digit_o(digit)
  );

  bcd_bus_drive #(.DIGIT_W(DIGIT_W)) u_drive (
    .oe_i(oe_i), .digit_i(digit), .data_o(bcd_data_o), .drv_o(bcd_drv_o)
  );

  AST_TOP_UPPER_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i[SEL_W-1] |-> bcd_data_o[DIGIT_W-1:TOP_W] == '0); // R6
  AST_OFF_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |-> (bcd_drv_o == '0 && bcd_data_o == '0)); // R7
  AST_ON_FULL_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_i |-> bcd_drv_o == '1); // R7
  AST_TOP_PICKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_i && sel_i[SEL_W-1] && $past(xfer_i) && $past(rst_ni))
      |-> bcd_data_o[TOP_W-1:0] == $past(count_i[CNT_W-1 -: TOP_W])); // R5
endmodule

// File: tb/bcd_digit_readout_tb.sv
`timescale 1ns/1ps
module bcd_digit_readout_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [16:0] count = '0;
  logic        xfer = 1'b0;
  logic [2:0]  sel = '0;
  logic        oe = 1'b0;
  logic [3:0]  data, drv;

  int n_chk = 0;
  int n_bad = 0;
  logic [16:0] cap = '0;
  bit done = 0;

  always #4 clk = ~clk;

  bcd_digit_readout dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .count_i(count), .xfer_i(xfer),
    .sel_i(sel), .oe_i(oe), .bcd_data_o(data), .bcd_drv_o(drv)
  );

  function automatic logic [3:0] exp_data(logic [16:0] c, logic [2:0] s, logic e);
    if (!e) return 4'h0;
    if (s[2]) return {3'b000, c[16]};
    return c[s[1:0]*4 +: 4];
  endfunction

  function automatic logic [16:0] rand_bcd();
    logic [16:0] v;
    for (int k = 0; k < 4; k++) v[k*4 +: 4] = 4'($urandom % 10);
    v[16] = 1'($urandom % 2);
    return v;
  endfunction

  task automatic check(string tag);
    logic [3:0] ed, ev;
    ed = exp_data(cap, sel, oe);
    ev = oe ? 4'hF : 4'h0;
    n_chk++;
    if (data !== ed || drv !== ev) begin
      n_bad++;
      $display("FAIL %s sel=%b oe=%b data=%h exp=%h drv=%b exp=%b", tag, sel, oe, data, ed, drv, ev);
    end
  endtask

  // one clock with given inputs, then check after the edge
  task automatic step(logic [16:0] c, logic x, logic [2:0] s, logic e, string tag);
    @(negedge clk);
    count = c; xfer = x; sel = s; oe = e;
    @(posedge clk);
    if (x) cap = c;
    #2;
    check(tag);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_ni = 1'b1;
    // R1: cleared after reset
    for (int s = 0; s < 8; s++) step(17'h1_5555, 1'b0, 3'(s), 1'b1, "R1");
    // R2: load 1_9876, every digit distinct
    step(17'h1_9876, 1'b1, 3'b000, 1'b1, "R2");
    // R3: count moves while transfer low
    step(17'h0_1234, 1'b0, 3'b000, 1'b1, "R3");
    // R4: digits 1..4
    for (int s = 0; s < 4; s++) step(17'h0_4321, 1'b0, 3'(s), 1'b1, "R4");
    // R5 / R6: top digit under all low select bits
    for (int s = 4; s < 8; s++) step(17'h0_0000, 1'b0, 3'(s), 1'b1, "R5_R6");
    // R6: top digit 0 while lower digits are 9s
    step(17'h0_9999, 1'b1, 3'b111, 1'b1, "R6");
    // R7: bus disabled
    step(17'h1_2222, 1'b0, 3'b010, 1'b0, "R7");
    step(17'h1_2222, 1'b0, 3'b100, 1'b0, "R7");
    // R8: select and enable changes take effect without a clock edge
    @(negedge clk);
    xfer = 1'b0; oe = 1'b1; sel = 3'b011; #1; check("R8");
    sel = 3'b001; #1; check("R8");
    oe = 1'b0; #1; check("R8");
    oe = 1'b1; sel = 3'b110; #1; check("R8");
    // random mix of load, hold and readout
    for (int i = 0; i < 400; i++) begin
      step(rand_bcd(), 1'($urandom % 3 == 0), 3'($urandom), 1'($urandom % 4 != 0), "R2_R3_R4_R5_R7");
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule